// File: doc/BRIEF.md
# Register File Write-Port Arbiter

This block sits between a five-stage pipeline and its register file. In this pipeline, register-register results are written back from the memory stage, and load results are written back one stage later. A load followed at once by an independent ALU instruction therefore sends two writes to the register file in the same cycle. The arbiter takes both write requests, each with a destination register number and data, and decides which one reaches the register file write port.

With the default single write port, the older load wins. The ALU write is parked in a one-entry holding register, and a stall output freezes the stages upstream of the memory stage for one cycle, which costs one bubble. The parked write goes out on the next free cycle, ahead of any new ALU write.

With the parameter for two write ports set, both writes complete in the same cycle and no stall is raised. If both target the same register, only the younger ALU value is written. Writes to register 0 are dropped in both modes.

Top module: `rf_wport_arb`

## Requirements
- R1: A load write request with a nonzero register number is driven on port 0 in the same cycle, with its register number and data. In two-port mode this holds only when the ALU request targets a different register.
- R2: In single-port mode, an ALU write request that arrives with no load request and no parked write is driven on port 0 in the same cycle, and stall_o stays low.
- R3: In single-port mode, when a load request and an ALU request are both present and no write is parked, stall_o is high in that cycle and only the load is written.
- R4: A write parked by a stall is driven on port 0 in the next cycle that has no load request, with its original register number and data. stall_o is low in that cycle.
- R5: In single-port mode, while a write is parked, the ALU request inputs are ignored: their register number and data never reach the write port.
- R6: In single-port mode, if a new load request arrives while a write is parked, the load is written, stall_o stays high, and the parked write is kept for a later cycle.
- R7: A request that targets register 0 is never written and never causes a stall, in either mode.
- R8: In single-port mode, the port 1 write enable is always low.
- R9: In two-port mode, a load and an ALU request to different registers are written in the same cycle, the load on port 0 and the ALU on port 1, and stall_o is never high.
- R10: In two-port mode, when the load and the ALU request target the same register, port 0 writes nothing and port 1 writes the ALU data.
- R11: Reset empties the holding register. After reset, no write is issued until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_vld_i | input | 1 | ALU result write request from the memory stage |
| mem_rd_i | input | ADDR_W | Destination register of the ALU result |
| mem_data_i | input | DATA_W | ALU result data |
| ld_vld_i | input | 1 | Load data write request from the writeback stage |
| ld_rd_i | input | ADDR_W | Destination register of the load |
| ld_data_i | input | DATA_W | Load data |
| stall_o | output | 1 | Freezes the pipeline registers upstream of the memory stage |
| p0_we_o | output | 1 | Port 0 write enable |
| p0_rd_o | output | ADDR_W | Port 0 register number |
| p0_data_o | output | DATA_W | Port 0 write data |
| p1_we_o | output | 1 | Port 1 write enable (two-port mode only) |
| p1_rd_o | output | ADDR_W | Port 1 register number |
| p1_data_o | output | DATA_W | Port 1 write data |

## Verification
Some properties are checked on every cycle by assertions. These are: a valid load always owns port 0, a clash raises the stall, a parked write is captured intact and then issued, register 0 is never written, and in two-port mode the younger ALU value wins a same-register clash. Other behaviours need a sequence of cycles, so only the bench scenarios can show them. These are that ALU inputs offered while a write is parked never reach the register file, that a parked write survives a second consecutive load, and that reset throws away a parked write. The scoreboard also runs a single-port instance and a two-port instance on the same stimulus, so the two modes are compared cycle by cycle.

// File: rtl/rf_arb_pkg.sv
package rf_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_HELD = 2'd2,
    SRC_ALU  = 2'd3
  } wsrc_e;
endpackage

// File: rtl/rf_arb_qual.sv
module rf_arb_qual #(
  parameter int ADDR_W = 5
) (
  input  logic              vld_i,
  input  logic [ADDR_W-1:0] rd_i,
  output logic              req_o
);
  // register 0 is hardwired: such writes are dropped
  assign req_o = vld_i && (rd_i != '0);
endmodule

// File: rtl/rf_arb_hold.sv
module rf_arb_hold #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] rd_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      rd_o   <= '0;
      data_o <= '0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) begin
        rd_o   <= rd_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/rf_wport_arb.sv
module rf_wport_arb
  import rf_arb_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter bit DUAL_PORT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_vld_i,
  input  logic [ADDR_W-1:0] mem_rd_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              ld_vld_i,
  input  logic [ADDR_W-1:0] ld_rd_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              stall_o,
  output logic              p0_we_o,
  output logic [ADDR_W-1:0] p0_rd_o,
  output logic [DATA_W-1:0] p0_data_o,
  output logic              p1_we_o,
  output logic [ADDR_W-1:0] p1_rd_o,
  output logic [DATA_W-1:0] p1_data_o
);

  logic ld_req, mem_req;

  rf_arb_qual #(.ADDR_W(ADDR_W)) u_ld_qual  (.vld_i(ld_vld_i),  .rd_i(ld_rd_i),  .req_o(ld_req));
  rf_arb_qual #(.ADDR_W(ADDR_W)) u_mem_qual (.vld_i(mem_vld_i), .rd_i(mem_rd_i), .req_o(mem_req));

  generate
    if (!DUAL_PORT) begin : g_single
      logic              held_vld;
      logic [ADDR_W-1:0] held_rd;
      logic [DATA_W-1:0] held_data;
      logic              alu_req, cand_req, clash;
      logic [ADDR_W-1:0] cand_rd;
      logic [DATA_W-1:0] cand_data;
      wsrc_e             sel;

      always_comb begin
        // upstream is frozen while a write is parked: MEM inputs carry no new work
        alu_req   = mem_req && !held_vld;
        cand_req  = held_vld || alu_req;
        cand_rd   = held_vld ? held_rd   : mem_rd_i;
        cand_data = held_vld ? held_data : mem_data_i;
        clash     = ld_req && cand_req;
        if (ld_req)        sel = SRC_LOAD;
        else if (held_vld) sel = SRC_HELD;
        else if (alu_req)  sel = SRC_ALU;
        else               sel = SRC_NONE;
      end

      always_comb begin
        p0_we_o   = 1'b1;
        p0_rd_o   = '0;
        p0_data_o = '0;
        unique case (sel)
          SRC_LOAD: begin p0_rd_o = ld_rd_i;  p0_data_o = ld_data_i;  end
          SRC_HELD: begin p0_rd_o = held_rd;  p0_data_o = held_data;  end
          SRC_ALU:  begin p0_rd_o = mem_rd_i; p0_data_o = mem_data_i; end
          default:  p0_we_o = 1'b0;
        endcase
      end

      rf_arb_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cap_i  (clash),
        .rd_i   (cand_rd),
        .data_i (cand_data),
        .vld_o  (held_vld),
        .rd_o   (held_rd),
        .data_o (held_data)
      );

      assign stall_o   = clash;
      assign p1_we_o   = 1'b0;
      assign p1_rd_o   = '0;
      assign p1_data_o = '0;

      AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_vld_i && ld_rd_i != '0) |-> (p0_we_o && p0_rd_o == ld_rd_i && p0_data_o == ld_data_i)); // R1
      AST_CLASH_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_vld_i && ld_rd_i != '0 && mem_vld_i && mem_rd_i != '0 && !held_vld) |-> stall_o); // R3
      AST_HELD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && !held_vld) |=> (held_vld && held_rd == $past(mem_rd_i) && held_data == $past(mem_data_i))); // R4
      AST_HELD_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held_vld && !(ld_vld_i && ld_rd_i != '0)) |-> (p0_we_o && p0_rd_o == held_rd && p0_data_o == held_data && !stall_o)); // R4
      AST_HELD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held_vld && stall_o) |=> (held_vld && $stable(held_rd) && $stable(held_data))); // R6
      AST_STALL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (ld_vld_i && ld_rd_i != '0)); // R7
    end else begin : g_dual
      logic same_rd;

      assign same_rd   = ld_req && mem_req && (ld_rd_i == mem_rd_i);
      // younger ALU value wins a same-register collision
      assign p0_we_o   = ld_req && !same_rd;
      assign p0_rd_o   = ld_rd_i;
      assign p0_data_o = ld_data_i;
      assign p1_we_o   = mem_req;
      assign p1_rd_o   = mem_rd_i;
      assign p1_data_o = mem_data_i;
      assign stall_o   = 1'b0;

      AST_DUAL_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_vld_i && ld_rd_i != '0 && mem_vld_i && mem_rd_i != '0 && ld_rd_i != mem_rd_i)
          |-> (p0_we_o && p1_we_o && p0_data_o == ld_data_i && p1_data_o == mem_data_i)); // R9
      AST_DUAL_YOUNGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_vld_i && mem_vld_i && mem_rd_i != '0 && ld_rd_i == mem_rd_i)
          |-> (!p0_we_o && p1_we_o && p1_data_o == mem_data_i)); // R10
      AST_P1_NO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p1_we_o |-> (p1_rd_o != '0)); // R7
    end
  endgenerate

  AST_P0_NO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p0_we_o |-> (p0_rd_o != '0)); // R7

endmodule

// File: tb/rf_wport_arb_tb.sv
module rf_wport_arb_tb;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          mem_vld = 1'b0, ld_vld = 1'b0;
  logic [AW-1:0] mem_rd = '0, ld_rd = '0;
  logic [DW-1:0] mem_data = '0, ld_data = '0;

  logic          s_st, s_we0, s_we1, d_st, d_we0, d_we1;
  logic [AW-1:0] s_rd0, s_rd1, d_rd0, d_rd1;
  logic [DW-1:0] s_d0, s_d1, d_d0, d_d1;

  rf_wport_arb #(.ADDR_W(AW), .DATA_W(DW), .DUAL_PORT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_vld_i(mem_vld), .mem_rd_i(mem_rd), .mem_data_i(mem_data),
    .ld_vld_i(ld_vld), .ld_rd_i(ld_rd), .ld_data_i(ld_data),
    .stall_o(s_st), .p0_we_o(s_we0), .p0_rd_o(s_rd0), .p0_data_o(s_d0),
    .p1_we_o(s_we1), .p1_rd_o(s_rd1), .p1_data_o(s_d1));

  rf_wport_arb #(.ADDR_W(AW), .DATA_W(DW), .DUAL_PORT(1'b1)) u_dut_dual (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_vld_i(mem_vld), .mem_rd_i(mem_rd), .mem_data_i(mem_data),
    .ld_vld_i(ld_vld), .ld_rd_i(ld_rd), .ld_data_i(ld_data),
    .stall_o(d_st), .p0_we_o(d_we0), .p0_rd_o(d_rd0), .p0_data_o(d_d0),
    .p1_we_o(d_we1), .p1_rd_o(d_rd1), .p1_data_o(d_d1));

  typedef struct {
    string         tag;
    logic          s_st, s_we0;
    logic [AW-1:0] s_rd0;
    logic [DW-1:0] s_d0;
    logic          d_we0, d_we1;
    logic [AW-1:0] d_rd0, d_rd1;
    logic [DW-1:0] d_d0, d_d1;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // reference state: parked write of the single-port variant
  logic          m_hv = 1'b0;
  logic [AW-1:0] m_hr = '0;
  logic [DW-1:0] m_hd = '0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic lv, logic [AW-1:0] lr, logic [DW-1:0] ld,
                       logic mv, logic [AW-1:0] mr, logic [DW-1:0] md);
    exp_t e;
    logic lq, mq, mq2, cq, same;
    logic [AW-1:0] cr;
    logic [DW-1:0] cd;
    @(posedge clk);
    #1;
    ld_vld = lv; ld_rd = lr; ld_data = ld;
    mem_vld = mv; mem_rd = mr; mem_data = md;
    lq  = lv && lr != '0;
    mq2 = mv && mr != '0;
    mq  = mq2 && !m_hv;
    cq  = m_hv || mq;
    cr  = m_hv ? m_hr : mr;
    cd  = m_hv ? m_hd : md;
    e.tag   = tag;
    e.s_st  = lq && cq;
    e.s_we0 = lq || cq;
    e.s_rd0 = lq ? lr : cr;
    e.s_d0  = lq ? ld : cd;
    same    = lq && mq2 && lr == mr;
    e.d_we0 = lq && !same;
    e.d_rd0 = lr;
    e.d_d0  = ld;
    e.d_we1 = mq2;
    e.d_rd1 = mr;
    e.d_d1  = md;
    exp_q.push_back(e);
    if (lq && cq) begin m_hv = 1'b1; m_hr = cr; m_hd = cd; end
    else m_hv = 1'b0;
  endtask

  task automatic idle(string tag);
    drive(tag, 1'b0, '0, '0, 1'b0, '0, '0);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "stall", {31'd0, s_st}, {31'd0, e.s_st});
      chk(e.tag, "p0_we", {31'd0, s_we0}, {31'd0, e.s_we0});
      if (e.s_we0) begin
        chk(e.tag, "p0_rd", {27'd0, s_rd0}, {27'd0, e.s_rd0});
        chk(e.tag, "p0_data", s_d0, e.s_d0);
      end
      chk("R8", "single p1_we", {31'd0, s_we1}, 32'd0);
      chk(e.tag, "dual p0_we", {31'd0, d_we0}, {31'd0, e.d_we0});
      if (e.d_we0) begin
        chk(e.tag, "dual p0_rd", {27'd0, d_rd0}, {27'd0, e.d_rd0});
        chk(e.tag, "dual p0_data", d_d0, e.d_d0);
      end
      chk(e.tag, "dual p1_we", {31'd0, d_we1}, {31'd0, e.d_we1});
      if (e.d_we1) begin
        chk(e.tag, "dual p1_rd", {27'd0, d_rd1}, {27'd0, e.d_rd1});
        chk(e.tag, "dual p1_data", d_d1, e.d_d1);
      end
      chk("R9", "dual stall", {31'd0, d_st}, 32'd0);
    end
  end

  task automatic finish_run();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R11 reset state");
    drive("R2/R9 alu only",            1'b0, 5'd0,  32'h0,        1'b1, 5'd5,  32'hA000_0005);
    drive("R1/R3/R9 clash",            1'b1, 5'd3,  32'hB000_0003, 1'b1, 5'd7,  32'hA000_0007);
    drive("R4/R5/R9 parked issue",     1'b0, 5'd0,  32'h0,        1'b1, 5'd9,  32'hA000_0009);
    idle("R5 ignored alu absent");
    drive("R3 clash",                  1'b1, 5'd4,  32'hB000_0004, 1'b1, 5'd6,  32'hA000_0006);
    drive("R6 second load",            1'b1, 5'd8,  32'hB000_0008, 1'b1, 5'd10, 32'hA000_000A);
    idle("R4 late issue");
    drive("R7 load to r0",             1'b1, 5'd0,  32'hB000_0000, 1'b1, 5'd11, 32'hA000_000B);
    drive("R7 alu to r0",              1'b1, 5'd12, 32'hB000_000C, 1'b1, 5'd0,  32'hA000_0000);
    drive("R10/R3 same register",      1'b1, 5'd15, 32'hB000_000F, 1'b1, 5'd15, 32'hA000_000F);
    idle("R4 issue after same reg");
    drive("R1 load only",              1'b1, 5'd15, 32'hB100_000F, 1'b0, 5'd0,  32'h0);
    drive("R9/R3 max register",        1'b1, 5'd31, 32'hB000_001F, 1'b1, 5'd1,  32'hA000_0001);
    idle("R4 issue r1");
    drive("R3 clash before reset",     1'b1, 5'd2,  32'hB000_0002, 1'b1, 5'd3,  32'hA000_0003);
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
    #1;
    ld_vld = 1'b0; mem_vld = 1'b0;
    rst_n = 1'b0;
    m_hv = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R11 parked write discarded");
    drive("R2 alu after reset",        1'b0, 5'd0,  32'h0,        1'b1, 5'd20, 32'hA000_0014);
    finish_run();
  end
endmodule